// File: doc/BRIEF.md
# Reload-Based Watchdog Timer

This block guards a microcontroller subsystem against runaway software. Software arms it by writing a 1 to the enable position of a power-control register write. From then on an 8-bit counter climbs by one on every slow tick. The tick comes from a prescaler that divides the system clock. Software must keep writing a fresh 8-bit start value into the counter. If the counter rolls past its top value before the next such write, the block raises a system reset request for a fixed number of cycles.

Arming works one way only. A write of 0 cannot disarm the block. Only the synchronous reset input, or the block's own timeout, returns it to the disarmed state. The start value that software writes sets the timeout length: (256 − value) ticks.

Top module: `tick_watchdog`

## Requirements
- R1: After the synchronous reset input is high at a clock edge, `wd_enabled` is 0, `wd_count` is 0 and `sys_rst_req` is low. This holds even if the block was armed before the reset.
- R2: A power-control write with bit 4 of `ctrl_wdata` at 1 arms the block. `wd_enabled` reads 1 from the next cycle. Control writes with bit 4 at 0 do not arm the block, whatever the other bits hold.
- R3: Once the block is armed, a power-control write with bit 4 at 0 leaves `wd_enabled` at 1.
- R4: While the block is disarmed, `wd_count` stays 0, reload writes are ignored and `sys_rst_req` stays low.
- R5: While the block is armed, `wd_count` rises by one every TICK_CYCLES clock cycles. The first increment comes TICK_CYCLES cycles after the arming write.
- R6: A reload write while the block is armed loads `reload_val` into `wd_count` in the next cycle. It also restarts the prescaler, so the next increment comes a full TICK_CYCLES cycles after the reload.
- R7: When the counter steps from 0xFF to 0x00, `sys_rst_req` rises in the cycle after that step. This is exactly (256 − v) × TICK_CYCLES cycles after a reload of value v, and no request occurs otherwise.
- R8: `sys_rst_req` stays high for exactly PULSE_CYCLES cycles, then falls.
- R9: A timeout disarms the block: `wd_enabled` is 0 from the cycle in which `sys_rst_req` rises. Arming writes made while `sys_rst_req` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Write strobe for the power-control register |
| ctrl_wdata | input | 8 | Power-control write data; bit 4 arms the watchdog |
| reload_wr | input | 1 | Reload write strobe |
| reload_val | input | 8 | Counter start value for a reload |
| wd_enabled | output | 1 | Current state of the sticky enable bit |
| wd_count | output | 8 | Current counter value |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The hardest state to reach is an arming write that lands while the reset request is still high. It must be ignored, and nothing later in the run may show that it took effect. The stimulus first lets a reload expire, then issues the arming write in the cycle the request is first seen. After the pulse ends, the bench checks that the block is still disarmed and that no further request ever follows. The bench also predicts the exact cycle of each request from the reload value, and a scoreboard compares it with when the request actually rises.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0] wdt_count_t;

    typedef enum logic {
        PULSE_IDLE   = 1'b0,
        PULSE_ACTIVE = 1'b1
    } pulse_state_e;

    typedef struct packed {
        logic       load;
        wdt_count_t value;
    } reload_req_t;

    function automatic logic at_top(input wdt_count_t c);
        return c == {CNT_W{1'b1}};
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int TICK_CYCLES = 12000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

    logic [PW-1:0] phase_q;

    assign tick = run && !restart && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || restart || phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    initial begin
        if (TICK_CYCLES < 2) $error("TICK_CYCLES must be at least 2");
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST); // R5

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        tick,
    input  reload_req_t reload,
    output wdt_count_t  count,
    output logic        wrap
);
    wdt_count_t count_q;

    assign count = count_q;
    assign wrap  = tick && at_top(count_q);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count_q <= '0;
        end else if (reload.load) begin
            count_q <= reload.value;
        end else if (tick) begin
            count_q <= count_q + 1'b1;
        end
    end

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        (run && !reload.load && !tick) |=> $stable(count_q)); // R5

    AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (rst)
        (run && reload.load) |=> (count_q == $past(reload.value))); // R6

endmodule

// File: rtl/wdt_reset_pulse.sv
module wdt_reset_pulse
    import wdt_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trigger,
    output logic req
);
    localparam int PCW = $clog2(PULSE_CYCLES + 1);

    logic [PCW-1:0] remain_q;
    pulse_state_e   state;

    assign state = (remain_q != '0) ? PULSE_ACTIVE : PULSE_IDLE;
    assign req   = (state == PULSE_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (trigger) begin
            remain_q <= PCW'(PULSE_CYCLES);
        end else if (state == PULSE_ACTIVE) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    AST_RISE_FROM_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(trigger)); // R7

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        req |-> !trigger); // R8

endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import wdt_pkg::*;
#(
    parameter int TICK_CYCLES  = 12000,
    parameter int PULSE_CYCLES = 16,
    parameter int ENABLE_BIT   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    input  logic       reload_wr,
    input  logic [7:0] reload_val,
    output logic       wd_enabled,
    output logic [7:0] wd_count,
    output logic       sys_rst_req
);
    logic        en_q;
    logic        tick;
    logic        wrap;
    logic        req;
    wdt_count_t  cnt;
    reload_req_t reload;

    assign reload.load  = reload_wr && en_q;
    assign reload.value = reload_val;

    always_ff @(posedge clk) begin
        if (rst || wrap || req) begin
            en_q <= 1'b0;
        end else if (ctrl_wr && ctrl_wdata[ENABLE_BIT]) begin
            en_q <= 1'b1;
        end
    end

    wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (en_q),
        .restart (reload.load),
        .tick    (tick)
    );

    wdt_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (en_q),
        .tick   (tick),
        .reload (reload),
        .count  (cnt),
        .wrap   (wrap)
    );

    wdt_reset_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .trigger (wrap),
        .req     (req)
    );

    assign wd_enabled  = en_q;
    assign wd_count    = cnt;
    assign sys_rst_req = req;

    AST_DISARMED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (cnt == '0)); // R4

    AST_STICKY_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (en_q && !wrap) |=> en_q); // R3

    AST_PULSE_DISARMS: assert property (@(posedge clk) disable iff (rst)
        req |-> !en_q); // R9

endmodule

// File: tb/tick_watchdog_tb.sv
module tick_watchdog_tb_top;
    localparam int T = 4;
    localparam int P = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'h00;
    logic       reload_wr = 1'b0;
    logic [7:0] reload_val = 8'h00;
    logic       wd_enabled;
    logic [7:0] wd_count;
    logic       sys_rst_req;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int exp_q[$];
    logic prev_req = 1'b0;
    int   high_len = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tick_watchdog #(.TICK_CYCLES(T), .PULSE_CYCLES(P)) dut_i (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .reload_wr(reload_wr), .reload_val(reload_val),
        .wd_enabled(wd_enabled), .wd_count(wd_count), .sys_rst_req(sys_rst_req)
    );

    task automatic check(input string req_tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req_tag, cyc, act, expv);
        end
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic ctrl_write(input logic [7:0] d, output int edge_n);
        edge_n = cyc + 1;
        ctrl_wr = 1'b1; ctrl_wdata = d;
        @(negedge clk);
        ctrl_wr = 1'b0; ctrl_wdata = 8'h00;
    endtask

    task automatic reload_write(input logic [7:0] v, input bit expect_to, output int edge_n);
        edge_n = cyc + 1;
        reload_wr = 1'b1; reload_val = v;
        if (expect_to) exp_q.push_back(edge_n + (256 - int'(v)) * T);
        @(negedge clk);
        reload_wr = 1'b0; reload_val = 8'h00;
    endtask

    // Monitor: scoreboard of request rise times (R7) and pulse widths (R8)
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (sys_rst_req && !prev_req) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected request", cyc, -1);
                end else begin
                    check("R7 request timing", cyc, exp_q.pop_front());
                end
            end
            if (sys_rst_req) high_len++;
            if (!sys_rst_req && prev_req) begin
                check("R8 pulse width", high_len, P);
                high_len = 0;
            end
        end
        prev_req = sys_rst_req;
    end

    initial begin
        while (cyc < 20000 && !done) @(negedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired: actual=%0d expected<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int e;
        int r;
        int ov;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 enable", wd_enabled, 0);
        check("R1 count", wd_count, 0);
        check("R1 request", sys_rst_req, 0);

        // R2 writes without bit 4 do not arm
        ctrl_write(8'hEF, e);
        repeat (2) @(negedge clk);
        check("R2 no arm", wd_enabled, 0);

        // R4 reload while disarmed ignored
        reload_write(8'h80, 1'b0, r);
        check("R4 reload ignored", wd_count, 0);
        repeat (T * 2) @(negedge clk);
        check("R4 still zero", wd_count, 0);
        check("R4 no request", sys_rst_req, 0);

        // R2/R5 arm and tick timing
        ctrl_write(8'h10, e);
        check("R2 armed", wd_enabled, 1);
        wait_until(e + T - 1);
        check("R5 before first tick", wd_count, 0);
        wait_until(e + T);
        check("R5 first tick", wd_count, 1);
        wait_until(e + 3 * T);
        check("R5 third tick", wd_count, 3);

        // R3 writing 0 keeps it armed
        ctrl_write(8'h00, e);
        check("R3 sticky", wd_enabled, 1);

        // R6 reload mid-interval restarts prescaler
        wait_until(cyc + 1);
        reload_write(8'hF0, 1'b1, r);
        check("R6 loaded", wd_count, 8'hF0);
        wait_until(r + T - 1);
        check("R6 full interval", wd_count, 8'hF0);
        wait_until(r + T);
        check("R6 step after reload", wd_count, 8'hF1);

        // R7/R9 expiry; arming write during pulse ignored
        ov = r + 16 * T;
        wait_until(ov);
        check("R9 disarmed at request", wd_enabled, 0);
        ctrl_write(8'h10, e);
        wait_until(ov + P + 2);
        check("R9 arm during pulse ignored", wd_enabled, 0);
        check("R4 count after timeout", wd_count, 0);
        repeat (20 * T) @(negedge clk);

        // Periodic reloads keep it quiet
        ctrl_write(8'h10, e);
        for (int i = 0; i < 8; i++) begin
            reload_write(8'hFC, 1'b0, r);
            repeat (9) @(negedge clk);
        end
        reload_write(8'hFC, 1'b1, r);
        wait_until(r + 3 * T);
        check("R5 count before wrap", wd_count, 8'hFF);
        wait_until(r + 4 * T + P + 2);
        check("R9 disarmed after wrap", wd_enabled, 0);

        // R7 max value: one tick timeout
        ctrl_write(8'h10, e);
        reload_write(8'hFF, 1'b1, r);
        wait_until(r + T + P + 2);

        // R1 reset clears an armed block
        ctrl_write(8'h10, e);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset disarms", wd_enabled, 0);
        check("R1 reset count", wd_count, 0);

        // R7 arm without reload: 256 ticks from zero
        ctrl_write(8'h10, e);
        exp_q.push_back(e + 256 * T);
        wait_until(e + 256 * T + P + 4);

        check("R7 all requests seen", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule